// File: doc/BRIEF.md
# I2C Byte Master with Per-Byte Handshake

This block is a byte-level I2C bus master that software controls through four small registers: a data byte, a command register, a status register and a clock divider. Software places the slave address (with the read/write flag in bit 0) in the data register and then issues a start command. The engine sends the start condition and the address. From then on it stops at every byte boundary. It raises a pending flag together with a coded master state, and it waits until software releases it with the next command.

For reads, the engine does not settle the acknowledge bit of a received byte when the byte arrives. The next command settles it. A plain continue acknowledges the byte and fetches another one. Stop or start, issued with continue, sends a not-acknowledge and then a stop condition or a repeated start. The bus lines are open drain: the block only pulls SCL and SDA low through output enables, and it samples SDA through a synchronizer.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status register reads 0x01 (pending set, state idle), the divider reads its default value CLK_HZ/(4*BUS_HZ)-1, and both output enables are low.
- R2: Register offsets are 0 data, 1 command, 2 status, 3 divider. The divider reads back what was written. Status bit 0 is pending and bits 3..1 hold the state: 0 idle, 1 received byte ready, 2 ready to transmit, 3 address not acknowledged, 4 data not acknowledged. Command bit 0 is continue, bit 1 is start and bit 2 is stop. A command register write acts as a single-cycle pulse.
- R3: A start command issued while idle produces exactly one start condition and then transmits the data register byte as the address. If the slave does not acknowledge the address, status becomes 0x07.
- R4: An acknowledged write address gives status 0x05. Continue then transmits the data register byte. An acknowledged data byte gives status 0x05 again, and a data byte that is not acknowledged gives status 0x09.
- R5: An acknowledged read address goes straight on to receive the first byte without stalling. Status then reads 0x03 and the data register holds the received byte.
- R6: Continue alone, while a received byte is pending, drives an acknowledge for that byte and receives the next byte. The result is again status 0x03 with the new byte in the data register.
- R7: Stop with continue, while a received byte is pending, sends a not-acknowledge and then a stop condition. Any completed stop leaves status at 0x01.
- R8: Start with continue, while any byte is pending, issues a repeated start with no stop condition in between, using the address now in the data register. A pending received byte is not-acknowledged first.
- R9: With divider value D, every SCL high and low phase within a transfer lasts 2*(D+1) clock cycles, so a bit takes 4*(D+1) cycles.
- R10: The block never drives the bus high. It releases both lines when idle, and SDA moves while SCL is high only to form the start and stop conditions that were commanded.
- R11: A command written while no byte is pending (engine busy) is ignored and does not disturb the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
The bench places a behavioural open-drain slave on the wired bus. That slave counts start and stop conditions and master acknowledges. A design that settled the read acknowledge when the byte arrived, instead of on the following command, would show up as a wrong acknowledge count or a missing not-acknowledge before a stop or a repeated start. A repeated start that slipped a stop in between, or an SDA edge while SCL is high, changes the condition counts. Phase-length errors in the divider appear as wrong minimum SCL high and low widths at two divider settings. A command accepted while the engine was busy would corrupt the first received byte or its status.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [2:0] {
      MS_IDLE  = 3'd0,
      MS_RXRDY = 3'd1,
      MS_TXRDY = 3'd2,
      MS_ANAK  = 3'd3,
      MS_DNAK  = 3'd4
   } mstate_e;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_START, SQ_BYTE, SQ_ACK, SQ_STOP, SQ_WAIT
   } seq_e;

   typedef enum logic [1:0] {
      NX_READ, NX_STOP, NX_RESTART
   } next_e;

   localparam logic [1:0] RA_DATA = 2'd0;
   localparam logic [1:0] RA_CMD  = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;
   localparam logic [1:0] RA_DIV  = 2'd3;

   localparam int CB_CONT  = 0;
   localparam int CB_START = 1;
   localparam int CB_STOP  = 2;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2+((STAGES>1)?0:1):0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt >= div) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt >= div);

   // R9: a nonzero divider never yields back-to-back ticks
   p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> !tick);

   // R9: the phase counter stays inside the divider range
   p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $stable(div)) |-> (cnt <= div));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
   import i2cm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       cmd_go,
   input  logic [2:0] cmd,
   input  logic [7:0] dat_q,
   input  logic       sda_s,
   output logic       run,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       pend,
   output logic [2:0] mst_o,
   output logic       rx_load,
   output logic [7:0] rx_byte
);
   seq_e       st;
   mstate_e    mst;
   next_e      nxt;
   logic [1:0] phase;
   logic [2:0] bitn;
   logic [7:0] shreg;
   logic       is_addr, rd_mode, held, ack_drv, ack_s, sda_q;
   logic       reading, cmd_ok;

   assign reading = rd_mode && !is_addr;

   always_comb begin
      cmd_ok = 1'b0;
      if (cmd_go && pend) begin
         if (st == SQ_IDLE)
            cmd_ok = cmd[CB_START];
         else if (st == SQ_WAIT && mst == MS_RXRDY)
            cmd_ok = cmd[CB_CONT];
         else if (st == SQ_WAIT)
            cmd_ok = cmd[CB_STOP] || cmd[CB_START] ||
                     (cmd[CB_CONT] && mst == MS_TXRDY);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_IDLE;   mst <= MS_IDLE;  nxt <= NX_READ;
         phase <= '0;     bitn <= '0;      shreg <= '0;
         is_addr <= 1'b0; rd_mode <= 1'b0; held <= 1'b0;
         ack_drv <= 1'b0; ack_s <= 1'b1;   sda_q <= 1'b0;
         pend <= 1'b1;    rx_load <= 1'b0;
      end else begin
         rx_load <= 1'b0;
         if (cmd_ok) begin
            pend  <= 1'b0;
            phase <= '0;
            if (st == SQ_IDLE) begin
               st <= SQ_START;
            end else if (mst == MS_RXRDY) begin
               st      <= SQ_ACK;
               ack_drv <= !(cmd[CB_STOP] || cmd[CB_START]);
               nxt     <= cmd[CB_STOP] ? NX_STOP :
                          (cmd[CB_START] ? NX_RESTART : NX_READ);
            end else if (cmd[CB_STOP]) begin
               st <= SQ_STOP;
            end else if (cmd[CB_START]) begin
               st <= SQ_START;
            end else begin
               st <= SQ_BYTE; shreg <= dat_q; bitn <= '0;
            end
         end else if (tick) begin
            phase <= phase + 2'd1;
            case (st)
               SQ_START: begin
                  if (phase == 2'd0) sda_q <= 1'b0;
                  if (phase == 2'd2) sda_q <= 1'b1;
                  if (phase == 2'd3) begin
                     st <= SQ_BYTE; shreg <= dat_q; rd_mode <= dat_q[0];
                     is_addr <= 1'b1; bitn <= '0; held <= 1'b1;
                  end
               end
               SQ_BYTE: begin
                  if (phase == 2'd0) sda_q <= reading ? 1'b0 : !shreg[7];
                  if (phase == 2'd2) shreg <= {shreg[6:0], sda_s};
                  if (phase == 2'd3) begin
                     bitn <= bitn + 3'd1;
                     if (bitn == 3'd7) begin
                        if (reading) begin
                           st <= SQ_WAIT; mst <= MS_RXRDY;
                           pend <= 1'b1; rx_load <= 1'b1;
                        end else begin
                           st <= SQ_ACK; ack_drv <= 1'b0;
                        end
                     end
                  end
               end
               SQ_ACK: begin
                  if (phase == 2'd0) sda_q <= ack_drv;
                  if (phase == 2'd2) ack_s <= sda_s;
                  if (phase == 2'd3) begin
                     bitn <= '0;
                     if (reading) begin
                        case (nxt)
                           NX_STOP:    st <= SQ_STOP;
                           NX_RESTART: st <= SQ_START;
                           default:    st <= SQ_BYTE;
                        endcase
                     end else if (is_addr) begin
                        is_addr <= 1'b0;
                        if (ack_s) begin
                           st <= SQ_WAIT; mst <= MS_ANAK; pend <= 1'b1;
                        end else if (rd_mode) begin
                           st <= SQ_BYTE;
                        end else begin
                           st <= SQ_WAIT; mst <= MS_TXRDY; pend <= 1'b1;
                        end
                     end else begin
                        st   <= SQ_WAIT; pend <= 1'b1;
                        mst  <= ack_s ? MS_DNAK : MS_TXRDY;
                     end
                  end
               end
               SQ_STOP: begin
                  if (phase == 2'd0) sda_q <= 1'b1;
                  if (phase == 2'd2) sda_q <= 1'b0;
                  if (phase == 2'd3) begin
                     st <= SQ_IDLE; held <= 1'b0;
                     mst <= MS_IDLE; pend <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign run = (st == SQ_START) || (st == SQ_BYTE) ||
                (st == SQ_ACK)   || (st == SQ_STOP);

   always_comb begin
      case (st)
         SQ_WAIT:  scl_oe = 1'b1;
         SQ_START: scl_oe = held && (phase < 2'd2);
         SQ_BYTE, SQ_ACK, SQ_STOP: scl_oe = (phase < 2'd2);
         default:  scl_oe = 1'b0;
      endcase
   end

   assign sda_oe  = sda_q;
   assign mst_o   = mst;
   assign rx_byte = shreg;

   // R10: inside a bit, SDA may not move while SCL is released
   p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_BYTE || st == SQ_ACK) && st == $past(st) &&
       !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

   // R10: idle engine leaves both lines released
   p_idle_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IDLE) |-> (!scl_oe && !sda_oe));

   // R6: a stalled engine holds SCL low
   p_wait_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_WAIT) |-> scl_oe);

   // R11: a stall always shows pending to software
   p_wait_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_WAIT) |-> pend);

   // R2: the reported state is one of the defined codes
   p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> (mst_o <= 3'd4));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cm_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BUS_HZ      = 100_000,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_in
);
   localparam int DEF_DIV = CLK_HZ / (4 * BUS_HZ) - 1;

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_w
         $error("DIV_W must lie in 1..8");
      end
      if (DEF_DIV < 0 || DEF_DIV >= (1 << DIV_W)) begin : g_bad_div
         $error("default divider does not fit DIV_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic [7:0]       data_q;
   logic [DIV_W-1:0] div_q;
   logic             cmd_go, run, tick, sda_s, pend, rx_load;
   logic [2:0]       mst;
   logic [7:0]       rx_byte;

   assign cmd_go = reg_wr && (reg_addr == RA_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         div_q  <= DIV_W'(DEF_DIV);
      end else begin
         if (rx_load)
            data_q <= rx_byte;
         else if (reg_wr && reg_addr == RA_DATA)
            data_q <= reg_wdata;
         if (reg_wr && reg_addr == RA_DIV)
            div_q <= reg_wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      case (reg_addr)
         RA_DATA: reg_rdata = data_q;
         RA_STAT: reg_rdata = {4'b0, mst, pend};
         RA_DIV:  reg_rdata = 8'(div_q);
         default: reg_rdata = 8'h00;
      endcase
   end

   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   i2cm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(run), .div(div_q), .tick(tick));

   i2cm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_go(cmd_go),
      .cmd(reg_wdata[2:0]), .dat_q(data_q), .sda_s(sda_s),
      .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe), .pend(pend),
      .mst_o(mst), .rx_load(rx_load), .rx_byte(rx_byte));

   // R1: status after reset shows ready and idle
   p_reset_stat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend && mst == 3'd0));
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       scl_oe, sda_oe;
   logic       s_drv = 1'b0;
   wire        scl = !scl_oe;
   wire        sda = !(sda_oe || s_drv);

   i2c_byte_master #(.CLK_HZ(200_000_000), .BUS_HZ(400_000)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda));

   always #2.5 clk = ~clk;

   int errs = 0, chks = 0;
   bit done = 1'b0;

   // ---------------- behavioural slave (address 0x2A) ----------------
   localparam logic [6:0] SADDR = 7'h2A;
   int n_start = 0, n_stop = 0, n_mack = 0, n_mnak = 0;
   int nwr = 0, nak_at = 99, rc = 0, txi = 0;
   logic [7:0] sh = 8'd0, txb = 8'd0;
   logic [7:0] wr_log [16];
   logic in_addr = 0, act = 0, txm = 0, match = 0, rw = 0, macked = 0, ld = 0;
   logic ps = 1, pd = 1;

   always @(negedge clk) begin
      if (!rst_n) begin
         act = 0; txm = 0; s_drv = 0; ps = 1; pd = 1;
      end else begin
         if (ps && scl && pd && !sda) begin
            n_start++; rc = 0; in_addr = 1; act = 1; txm = 0; s_drv = 0;
         end else if (ps && scl && !pd && sda) begin
            n_stop++; act = 0; txm = 0; s_drv = 0;
         end else if (act && scl && !ps) begin
            if (rc < 8) sh = {sh[6:0], sda};
            else if (txm) begin
               macked = !sda;
               if (sda) n_mnak++; else n_mack++;
            end
            rc++;
         end else if (act && !scl && ps) begin
            ld = 0;
            if (rc == 8) begin
               if (txm) s_drv = 0;
               else if (in_addr) begin
                  match = (sh[7:1] == SADDR); rw = sh[0]; s_drv = match;
               end else begin
                  wr_log[nwr[3:0]] = sh; s_drv = (nwr != nak_at); nwr++;
               end
            end else if (rc == 9) begin
               rc = 0; s_drv = 0;
               if (in_addr) begin
                  in_addr = 0;
                  if (!match) act = 0;
                  else if (rw) begin txm = 1; txi = 0; ld = 1; end
               end else if (txm) begin
                  if (macked) begin txi++; ld = 1; end
                  else txm = 0;
               end
               if (ld) begin txb = 8'hA0 + 8'(txi); s_drv = !txb[7]; end
            end else if (rc >= 1 && rc <= 7 && txm) begin
               s_drv = !txb[7-rc];
            end
         end
         ps = scl; pd = sda;
      end
   end

   // ---------------- SCL width monitor ----------------
   int hi_min = 999, lo_min = 999, wcnt = 0;
   logic mprev = 1;
   always @(negedge clk) begin
      if (scl == mprev) wcnt++;
      else begin
         if (mprev && wcnt < hi_min) hi_min = wcnt;
         if (!mprev && wcnt < lo_min) lo_min = wcnt;
         wcnt = 1;
      end
      mprev = scl;
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input int act_v, input int exp_v);
      chks++;
      if (act_v !== exp_v) begin
         errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act_v, exp_v);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      reg_addr = a;
      #1 v = int'(reg_rdata);
   endtask

   task automatic wait_pend(input string tag, output int s);
      s = 0;
      for (int i = 0; i < 20000; i++) begin
         rd(2'd2, s);
         if (s[0]) return;
      end
      chk({tag, " pending timeout"}, s, 1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      int v;
      rd(2'd2, v);  chk("R1 reset status", v, 8'h01);
      chk("R1 scl_oe at reset", int'(scl_oe), 0);
      chk("R1 sda_oe at reset", int'(sda_oe), 0);
      rd(2'd3, v);  chk("R1 default divider", v, 124);
      wr(2'd3, 8'd2);
      rd(2'd3, v);  chk("R2 divider readback", v, 2);
   endtask

   task automatic t_addr_nak();
      int v, s0, p0;
      s0 = n_start; p0 = n_stop;
      wr(2'd0, 8'h50); wr(2'd1, 8'h02);
      wait_pend("R3", v);      chk("R3 address NAK status", v, 8'h07);
      chk("R3 one start condition", n_start - s0, 1);
      wr(2'd1, 8'h04);
      wait_pend("R7", v);      chk("R7 status after stop", v, 8'h01);
      chk("R10 one stop condition", n_stop - p0, 1);
      chk("R10 bus released scl", int'(scl_oe), 0);
      chk("R10 bus released sda", int'(sda_oe), 0);
   endtask

   task automatic t_write();
      int v, s0, p0;
      logic [7:0] b [3];
      b[0] = 8'h11; b[1] = 8'h22; b[2] = 8'h33;
      nwr = 0; nak_at = 2; hi_min = 999; lo_min = 999;
      s0 = n_start; p0 = n_stop;
      wr(2'd0, 8'h54); wr(2'd1, 8'h02);
      wait_pend("R4", v);      chk("R4 write address ACK status", v, 8'h05);
      for (int i = 0; i < 3; i++) begin
         wr(2'd0, b[i]); wr(2'd1, 8'h01);
         wait_pend("R4", v);
         chk("R4 data byte status", v, (i < 2) ? 8'h05 : 8'h09);
         chk("R4 byte seen by slave", int'(wr_log[i]), int'(b[i]));
      end
      wr(2'd1, 8'h04);
      wait_pend("R7", v);      chk("R7 status after write stop", v, 8'h01);
      chk("R10 write starts", n_start - s0, 1);
      chk("R10 write stops", n_stop - p0, 1);
      chk("R9 SCL high width div=2", hi_min, 6);
      chk("R9 SCL low width div=2", lo_min, 6);
      nak_at = 99;
   endtask

   task automatic t_read();
      int v, a0, n0, p0;
      a0 = n_mack; n0 = n_mnak; p0 = n_stop;
      wr(2'd0, 8'h55); wr(2'd1, 8'h02);
      wr(2'd1, 8'h01);                       // busy: must be ignored (R11)
      wait_pend("R5", v);      chk("R5 first byte status", v, 8'h03);
      rd(2'd0, v);             chk("R5 first byte data", v, 8'hA0);
      chk("R11 no early ACK", n_mack - a0, 0);
      wr(2'd1, 8'h01);
      wait_pend("R6", v);      chk("R6 second byte status", v, 8'h03);
      rd(2'd0, v);             chk("R6 second byte data", v, 8'hA1);
      chk("R6 master ACK count", n_mack - a0, 1);
      wr(2'd1, 8'h01);
      wait_pend("R6", v);
      rd(2'd0, v);             chk("R6 third byte data", v, 8'hA2);
      wr(2'd1, 8'h05);
      wait_pend("R7", v);      chk("R7 status after read stop", v, 8'h01);
      chk("R7 final byte NAKed", n_mnak - n0, 1);
      chk("R7 total ACKs", n_mack - a0, 2);
      chk("R7 stop after read", n_stop - p0, 1);
   endtask

   task automatic t_restart();
      int v, s0, p0, k0, w0;
      s0 = n_start; p0 = n_stop; k0 = n_mnak; w0 = nwr;
      wr(2'd0, 8'h54); wr(2'd1, 8'h02);
      wait_pend("R8", v);      chk("R8 write address status", v, 8'h05);
      wr(2'd0, 8'h3C); wr(2'd1, 8'h01);
      wait_pend("R8", v);      chk("R8 write data status", v, 8'h05);
      chk("R8 written byte", int'(wr_log[w0]), 8'h3C);
      wr(2'd0, 8'h55); wr(2'd1, 8'h03);
      wait_pend("R8", v);      chk("R8 restart into read status", v, 8'h03);
      rd(2'd0, v);             chk("R8 restart read data", v, 8'hA0);
      chk("R8 two starts no stop (starts)", n_start - s0, 2);
      chk("R8 two starts no stop (stops)", n_stop - p0, 0);
      wr(2'd0, 8'h54); wr(2'd1, 8'h03);
      wait_pend("R8", v);      chk("R8 restart from read status", v, 8'h05);
      chk("R8 NAK before restart", n_mnak - k0, 1);
      wr(2'd1, 8'h04);
      wait_pend("R7", v);      chk("R7 status after restart stop", v, 8'h01);
      chk("R10 restart starts", n_start - s0, 3);
      chk("R10 restart stops", n_stop - p0, 1);
   endtask

   task automatic t_timing();
      int v, w0;
      wr(2'd3, 8'd5);
      hi_min = 999; lo_min = 999; w0 = nwr;
      wr(2'd0, 8'h54); wr(2'd1, 8'h02);
      wait_pend("R9", v);
      wr(2'd0, 8'h5A); wr(2'd1, 8'h01);
      wait_pend("R9", v);      chk("R9 data status div=5", v, 8'h05);
      wr(2'd1, 8'h04);
      wait_pend("R9", v);
      chk("R9 byte at div=5", int'(wr_log[w0]), 8'h5A);
      chk("R9 SCL high width div=5", hi_min, 12);
      chk("R9 SCL low width div=5", lo_min, 12);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_nak();
      t_write();
      t_read();
      t_restart();
      t_timing();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; chks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, chks);
         $finish;
      end
   end
endmodule